// File: doc/BRIEF.md
# Waveform Address Sequencer with Restart

This block produces the address of the waveform word being played. On each step it moves the address forward by one. When it reaches the end of the 13-bit space it wraps to 0. The waveform has no separate stop register. Instead, each stored word carries a small control nibble, and one bit of that nibble is a restart flag. When the word under the current address has its restart flag set, the next step jumps to the start address instead of counting up. Software fills every word past the stop point with the flag set. The waveform therefore restarts even if one reload was missed.

Two inputs from outside the play path also steer the address:
- **Force-load request.** A processor uses it for a return-to-start. It writes an arbitrary address into the counter and wins over every other action.
- **Reload inhibit.** It is held high while a processor is reading or writing waveform memory. It stops the restart flag from causing an accidental restart during that access. The counter keeps counting, so a later flagged word still restarts the waveform.

All pins are plain control and status pins. There is no data stream and no back-pressure: a step enable is taken in the cycle it is presented, and the address output is always valid.

Top module: `wave_addr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `addr_o` is 0.
- R2: With `run_i` and `step_i` both high, `force_i` low and no reload taken, `addr_o` rises by exactly one on the next clock.
- R3: Counting from address 8191 gives address 0 on the next clock.
- R4: If `run_i` or `step_i` is low and `force_i` is low, `addr_o` keeps its value on the next clock.
- R5: The restart flag is bit 0 of `ctrl_i`, where 1 means restart. A step taken with the flag at 1 and `no_load_i` low loads `start_i` into `addr_o` on the next clock.
- R6: While `no_load_i` is high, the restart flag is ignored and a step increments as in R2. While the flag is 0, `no_load_i` has no effect.
- R7: `force_i` high loads `force_addr_i` into `addr_o` on the next clock, whatever the values of `run_i`, `step_i`, `ctrl_i` and `no_load_i`.
- R8: A restart flag of 1 has no effect when no step is taken: `addr_o` holds.
- R9: Bits 3 to 1 of `ctrl_i` have no effect on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Waveform is playing |
| step_i | input | 1 | Synthesizer step enable |
| force_i | input | 1 | Force-load request (return to start) |
| force_addr_i | input | 13 | Address written by a force-load |
| start_i | input | 13 | Restart address |
| no_load_i | input | 1 | Reload inhibit during processor access |
| ctrl_i | input | 4 | Control nibble of the current word; bit 0 is the restart flag |
| addr_o | output | 13 | Current waveform address |

## Verification
Plain stepping checks the increment against a hold. Steps are presented with `run_i` low and, separately, with `step_i` low, which shows that both gates must be open for the address to move. A force-load to 8190 followed by two steps exercises the wrap.

The restart flag is tested in four situations:
- with a step, which separates a reload from an increment;
- with the inhibit high, where the same word must increment instead;
- with no step, where the address must hold;
- together with a force-load, which must win.

Nibbles that have only the upper bits set confirm that only bit 0 acts as the restart flag.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;
  typedef enum logic [1:0] {
    NXT_HOLD  = 2'd0,
    NXT_INC   = 2'd1,
    NXT_START = 2'd2,
    NXT_FORCE = 2'd3
  } nxt_sel_t;
endpackage

// File: rtl/wseq_decide.sv
module wseq_decide
  import wave_seq_pkg::*;
(
  input  logic     run_i,
  input  logic     step_i,
  input  logic     force_i,
  input  logic     flag_i,
  input  logic     no_load_i,
  output nxt_sel_t sel_o
);
  logic advance;
  logic reload_ok;

  assign advance   = run_i & step_i;
  assign reload_ok = flag_i & ~no_load_i;

  always_comb begin
    if (force_i)        sel_o = NXT_FORCE;
    else if (!advance)  sel_o = NXT_HOLD;
    else if (reload_ok) sel_o = NXT_START;
    else                sel_o = NXT_INC;
  end
endmodule

// File: rtl/wseq_next.sv
module wseq_next
  import wave_seq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  nxt_sel_t          sel_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] force_addr_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    unique case (sel_i)
      NXT_FORCE: nxt_o = force_addr_i;
      NXT_START: nxt_o = start_i;
      NXT_INC:   nxt_o = cur_i + ONE;
      default:   nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/wseq_reg.sv
module wseq_reg #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/wave_addr_seq.sv
module wave_addr_seq
  import wave_seq_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int CTRL_W   = 4,
  parameter int LOAD_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              step_i,
  input  logic              force_i,
  input  logic [ADDR_W-1:0] force_addr_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic              no_load_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [ADDR_W-1:0] addr_o
);
  nxt_sel_t          sel;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;
  logic              flag;

  assign flag = ctrl_i[LOAD_BIT];

  wseq_decide u_decide (
    .run_i     (run_i),
    .step_i    (step_i),
    .force_i   (force_i),
    .flag_i    (flag),
    .no_load_i (no_load_i),
    .sel_o     (sel)
  );

  wseq_next #(.ADDR_W(ADDR_W)) u_next (
    .sel_i        (sel),
    .cur_i        (addr_q),
    .start_i      (start_i),
    .force_addr_i (force_addr_i),
    .nxt_o        (addr_d)
  );

  wseq_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (addr_d),
    .q_o   (addr_q)
  );

  assign addr_o = addr_q;
endmodule

// File: rtl/wave_addr_seq_chk.sv
module wave_addr_seq_chk #(
  parameter int ADDR_W   = 13,
  parameter int CTRL_W   = 4,
  parameter int LOAD_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_i,
  input logic              step_i,
  input logic              force_i,
  input logic [ADDR_W-1:0] force_addr_i,
  input logic [ADDR_W-1:0] start_i,
  input logic              no_load_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic stepping;
  logic reload;
  assign stepping = run_i & step_i & ~force_i;
  assign reload   = ctrl_i[LOAD_BIT] & ~no_load_i;

  // R2
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && !reload) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && !reload && (&addr_o)) |=> addr_o == '0);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_i && !(run_i && step_i)) |=> $stable(addr_o));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && reload) |=> addr_o == $past(start_i));

  // R6
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && no_load_i) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  // R7
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> addr_o == $past(force_addr_i));
endmodule

bind wave_addr_seq wave_addr_seq_chk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .LOAD_BIT(LOAD_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .step_i(step_i),
  .force_i(force_i), .force_addr_i(force_addr_i), .start_i(start_i),
  .no_load_i(no_load_i), .ctrl_i(ctrl_i), .addr_o(addr_o)
);

// File: tb/test_wave_addr_seq.sv
module test_wave_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_i, step_i, force_i, no_load_i;
  logic [12:0] force_addr_i, start_i;
  logic [3:0]  ctrl_i;
  logic [12:0] addr_o;

  int n_total = 0;
  int n_pass  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  wave_addr_seq i_wave_addr_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .step_i(step_i),
    .force_i(force_i), .force_addr_i(force_addr_i), .start_i(start_i),
    .no_load_i(no_load_i), .ctrl_i(ctrl_i), .addr_o(addr_o)
  );

  task automatic chk(input string req, input logic [12:0] exp);
    n_total++;
    if (addr_o === exp) n_pass++;
    else $display("FAIL %s: addr_o=%0d expected %0d", req, addr_o, exp);
  endtask

  // inputs change at negedge; result sampled at the following negedge
  task automatic cyc(input logic run, input logic stp, input logic frc,
                     input logic [12:0] faddr, input logic [12:0] strt,
                     input logic [3:0] ctl, input logic nl);
    run_i = run; step_i = stp; force_i = frc; force_addr_i = faddr;
    start_i = strt; ctrl_i = ctl; no_load_i = nl;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0, 13'd0, 13'd0, 4'd0, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(); idle();
    chk("R1 during reset", 13'd0);
    rst_n = 1'b1;
    idle();
    chk("R1 after reset", 13'd0);
  endtask

  task automatic t_count();
    for (int i = 1; i <= 5; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd0, 4'd0, 1'b0);
      chk("R2 count", 13'(i));
    end
  endtask

  task automatic t_hold();
    cyc(1'b0, 1'b1, 1'b0, 13'd0, 13'd0, 4'd0, 1'b0);
    chk("R4 run low", 13'd5);
    cyc(1'b1, 1'b0, 1'b0, 13'd0, 13'd0, 4'd0, 1'b0);
    chk("R4 step low", 13'd5);
  endtask

  task automatic t_wrap();
    cyc(1'b0, 1'b0, 1'b1, 13'd8190, 13'd0, 4'd0, 1'b0);
    chk("R7 force while stopped", 13'd8190);
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd0, 4'd0, 1'b0);
    chk("R2 to top", 13'd8191);
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd0, 4'd0, 1'b0);
    chk("R3 wrap", 13'd0);
  endtask

  task automatic t_restart();
    cyc(1'b0, 1'b0, 1'b1, 13'd100, 13'd0, 4'd0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd20, 4'b0001, 1'b0);
    chk("R5 restart", 13'd20);
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd20, 4'b0000, 1'b0);
    chk("R5 resume count", 13'd21);
  endtask

  task automatic t_inhibit();
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd999, 4'b0001, 1'b1);
    chk("R6 inhibited flag", 13'd22);
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd999, 4'b0000, 1'b1);
    chk("R6 inhibit without flag", 13'd23);
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd999, 4'b0001, 1'b0);
    chk("R6 flag after inhibit drops", 13'd999);
  endtask

  task automatic t_no_step();
    cyc(1'b1, 1'b0, 1'b0, 13'd0, 13'd4, 4'b0001, 1'b0);
    chk("R8 flag without step", 13'd999);
    cyc(1'b0, 1'b1, 1'b0, 13'd0, 13'd4, 4'b0001, 1'b0);
    chk("R8 flag while stopped", 13'd999);
  endtask

  task automatic t_upper_bits();
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd7, 4'b1110, 1'b0);
    chk("R9 upper bits ignored", 13'd1000);
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd7, 4'b1111, 1'b0);
    chk("R9 flag with upper bits", 13'd7);
  endtask

  task automatic t_force_priority();
    cyc(1'b1, 1'b1, 1'b1, 13'd777, 13'd3, 4'b0001, 1'b0);
    chk("R7 force over restart", 13'd777);
    cyc(1'b1, 1'b1, 1'b1, 13'd4000, 13'd3, 4'b0000, 1'b1);
    chk("R7 force over count", 13'd4000);
    cyc(1'b1, 1'b1, 1'b0, 13'd0, 13'd3, 4'b0000, 1'b0);
    chk("R2 count after force", 13'd4001);
  endtask

  initial begin
    #300000;
    if (!done) begin
      n_total++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    run_i = 1'b0; step_i = 1'b0; force_i = 1'b0; no_load_i = 1'b0;
    force_addr_i = '0; start_i = '0; ctrl_i = '0;
    @(negedge clk);
    t_reset();
    t_count();
    t_hold();
    t_wrap();
    t_restart();
    t_inhibit();
    t_no_step();
    t_upper_bits();
    t_force_priority();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule